// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two byte-wide ports, A and B. Each data direction can pass through either the live value on the near port or a copy held in a per-direction storage register. Each direction has its own capture strobe and its own live-or-stored select. The two ports have output enables of opposite sense: the B port is driven when its enable is high, and the A port is driven when its enable is low. Each bidirectional pin is split into an input, an output and an output-enable, so the pads stay outside the block.

The capture strobes are sampled on the system clock. A low-to-high change seen between two clock edges loads the register at the later edge. The enables and selects never gate a capture. A register can therefore load while its port is isolated, while its port is driven, or while its own stored value is being forwarded. When a port is an output, its register loads the value being driven onto that port. If both ports are enabled and both selects ask for live data, the two paths would form a loop. The block breaks that loop by forwarding the stored registers instead, and raises a contention flag.

Top module: `regbus_xcvr`

## Requirements
- R1: `b_oe` equals `oe_b`, and `a_oe` equals the inverse of `oe_a_n`. The enable inputs have no other effect on capture.
- R2: With `sel_ab`=0 and no contention, `b_out` equals the A bus value: `a_in` when A is undriven, otherwise `a_out`. `sel_ba`=0 gives `a_out` the B bus value in the same way.
- R3: With `sel_ab`=1, `b_out` equals the A storage register. With `sel_ba`=1, `a_out` equals the B storage register.
- R4: If `cap_ab` is 1 at a clock edge and was 0 at the previous edge, the A register loads the A bus value at that edge. `cap_ba` does the same for the B register with the B bus value. A stored output shows the new value right after that edge, whatever the enables and selects are.
- R5: Without such a rising strobe, a register holds its value. This includes a strobe that stays high and input data that changes.
- R6: In isolation (`oe_b`=0, `oe_a_n`=1), neither port is driven, and both registers can still load from `a_in` and `b_in`.
- R7: While the A port is driven, a capture into the A register takes the driven `a_out` value. The same holds for B.
- R8: With both ports driven and both selects high, B carries the A register and A carries the B register in the same cycle.
- R9: `contention` is 1 exactly when both ports are driven and both selects are 0. In that case `b_out` carries the A register and `a_out` carries the B register.
- R10: A synchronous active-high `rst` clears both registers to zero and clears the strobe history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_b | input | 1 | B port drive enable, active high |
| oe_a_n | input | 1 | A port drive enable, active low |
| sel_ab | input | 1 | B port source: 0 live A, 1 stored A |
| sel_ba | input | 1 | A port source: 0 live B, 1 stored B |
| cap_ab | input | 1 | A register capture strobe |
| cap_ba | input | 1 | B register capture strobe |
| a_in | input | 8 | Value seen on A pins |
| a_out | output | 8 | Value to drive on A pins |
| a_oe | output | 1 | A pins driven |
| b_in | input | 8 | Value seen on B pins |
| b_out | output | 8 | Value to drive on B pins |
| b_oe | output | 1 | B pins driven |
| contention | output | 1 | Loop request detected, stored data forwarded |

## Verification
The assertions check four things on every cycle. A rising strobe loads its register with the bus value. Without a rising strobe the register holds. A strobe cannot rise on two edges in a row. The stored, live and loop-break routes send the right register or input to each enabled port. Only the bench scenarios can show the sequences behind these rules: capture during isolation read back later, capture of a driven value that came from the far side, the simultaneous swap, and the clearing done by reset. A sweep of every control combination with varied data compares all outputs against a bus model.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic drv_a;   // A pins driven
    logic drv_b;   // B pins driven
    logic jam;     // loop request, forced to stored paths
    logic use_qa;  // B port fed from A register
    logic use_qb;  // A port fed from B register
  } path_ctl_t;
endpackage

// File: rtl/xcvr_ctl.sv
module xcvr_ctl
  import xcvr_pkg::*;
(
  input  logic      oe_b,
  input  logic      oe_a_n,
  input  logic      sel_ab,
  input  logic      sel_ba,
  output path_ctl_t ctl
);
  logic both_drv;
  logic both_live;

  always_comb begin
    both_drv   = oe_b & ~oe_a_n;
    both_live  = ~sel_ab & ~sel_ba;
    ctl.drv_a  = ~oe_a_n;
    ctl.drv_b  = oe_b;
    ctl.jam    = both_drv & both_live;
    ctl.use_qa = sel_ab | ctl.jam;
    ctl.use_qb = sel_ba | ctl.jam;
  end
endmodule

// File: rtl/xcvr_rise.sv
module xcvr_rise (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= strobe;
  end

  assign rise = strobe & ~seen;

  // a strobe cannot produce a capture on two consecutive edges (R5)
  assert_rise_single_R5: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  assert_store_load_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(d));

  assert_store_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  path_ctl_t        ctl,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] qa,
  input  logic [WIDTH-1:0] qb,
  output logic [WIDTH-1:0] a_drv,
  output logic [WIDTH-1:0] b_drv,
  output logic [WIDTH-1:0] a_bus,
  output logic [WIDTH-1:0] b_bus
);
  // Without a loop, a live path whose source is itself driven
  // must be fed from that side's stored register.
  always_comb begin
    if (ctl.use_qb)     a_drv = qb;
    else if (ctl.drv_b) a_drv = qa;
    else                a_drv = b_in;

    if (ctl.use_qa)     b_drv = qa;
    else if (ctl.drv_a) b_drv = qb;
    else                b_drv = a_in;

    a_bus = ctl.drv_a ? a_drv : a_in;
    b_bus = ctl.drv_b ? b_drv : b_in;
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oe_b,
  input  logic             oe_a_n,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             cap_ab,
  input  logic             cap_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  output logic             contention
);
  path_ctl_t        ctl;
  logic             load_a, load_b;
  logic [WIDTH-1:0] qa, qb, a_bus, b_bus;

  xcvr_ctl u_ctl (
    .oe_b(oe_b), .oe_a_n(oe_a_n), .sel_ab(sel_ab), .sel_ba(sel_ba), .ctl(ctl)
  );

  xcvr_rise u_rise_a (.clk(clk), .rst(rst), .strobe(cap_ab), .rise(load_a));
  xcvr_rise u_rise_b (.clk(clk), .rst(rst), .strobe(cap_ba), .rise(load_b));

  xcvr_store #(.WIDTH(WIDTH)) u_store_a (
    .clk(clk), .rst(rst), .load(load_a), .d(a_bus), .q(qa)
  );
  xcvr_store #(.WIDTH(WIDTH)) u_store_b (
    .clk(clk), .rst(rst), .load(load_b), .d(b_bus), .q(qb)
  );

  xcvr_route #(.WIDTH(WIDTH)) u_route (
    .ctl(ctl), .a_in(a_in), .b_in(b_in), .qa(qa), .qb(qb),
    .a_drv(a_out), .b_drv(b_out), .a_bus(a_bus), .b_bus(b_bus)
  );

  assign a_oe       = ctl.drv_a;
  assign b_oe       = ctl.drv_b;
  assign contention = ctl.jam;

  assert_stored_b_R3: assert property (@(posedge clk) disable iff (rst)
    (oe_b && sel_ab) |-> b_out == qa);

  assert_stored_a_R3: assert property (@(posedge clk) disable iff (rst)
    (!oe_a_n && sel_ba) |-> a_out == qb);

  assert_live_b_R2: assert property (@(posedge clk) disable iff (rst)
    (oe_b && !sel_ab && oe_a_n) |-> b_out == a_in);

  assert_live_a_R2: assert property (@(posedge clk) disable iff (rst)
    (!oe_a_n && !sel_ba && !oe_b) |-> a_out == b_in);

  assert_loop_break_R9: assert property (@(posedge clk) disable iff (rst)
    contention |-> (a_out == qb && b_out == qa && a_oe && b_oe));
endmodule

// File: tb/sim_regbus_xcvr.sv
`timescale 1ns/1ps
module sim_regbus_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oe_b = 0, oe_a_n = 1, sel_ab = 0, sel_ba = 0, cap_ab = 0, cap_ba = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe, contention;

  int checks = 0;
  int errors = 0;

  // bus model state
  logic [W-1:0] mqa = '0, mqb = '0;
  logic pab = 1'b0, pba = 1'b0;
  logic edA, edB, econt;
  logic [W-1:0] ea, eb, abus, bbus;

  always #2.5 clk = ~clk;

  regbus_xcvr #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .oe_b(oe_b), .oe_a_n(oe_a_n), .sel_ab(sel_ab),
    .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba), .a_in(a_in),
    .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .contention(contention)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model();
    logic esab, esba;
    edA   = !oe_a_n;
    edB   = oe_b;
    econt = edA && edB && !sel_ab && !sel_ba;
    esab  = sel_ab || econt;
    esba  = sel_ba || econt;
    ea    = esba ? mqb : (edB ? mqa : b_in);
    eb    = esab ? mqa : (edA ? mqb : a_in);
    abus  = edA ? ea : a_in;
    bbus  = edB ? eb : b_in;
  endtask

  // drive at the falling edge, check, then advance the model at the rising edge
  task automatic step(string tag, logic r, logic ob, logic oan, logic sab,
                      logic sba, logic cab, logic cba, logic [W-1:0] ai,
                      logic [W-1:0] bi);
    string tb_, ta_;
    @(negedge clk);
    rst = r; oe_b = ob; oe_a_n = oan; sel_ab = sab; sel_ba = sba;
    cap_ab = cab; cap_ba = cba; a_in = ai; b_in = bi;
    #1;
    model();
    if (!r) begin
      tb_ = (tag != "") ? tag : (econt ? "R9" : (sab ? "R3" : "R2"));
      ta_ = (tag != "") ? tag : (econt ? "R9" : (sba ? "R3" : "R2"));
      chk("R1", "a_oe", a_oe, edA);
      chk("R1", "b_oe", b_oe, edB);
      chk("R9", "contention", contention, econt);
      if (edB) chk(tb_, "b_out", b_out, eb);
      if (edA) chk(ta_, "a_out", a_out, ea);
    end
    @(posedge clk);
    if (r) begin
      mqa = '0; mqb = '0; pab = 1'b0; pba = 1'b0;
    end else begin
      if (cab && !pab) mqa = abus;
      if (cba && !pba) mqb = bbus;
      pab = cab; pba = cba;
    end
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10: strobes during reset are discarded; registers read back zero
    step("", 1, 0, 1, 0, 0, 1, 1, 8'hAA, 8'h55);
    step("", 1, 0, 1, 0, 0, 0, 0, 8'hAA, 8'h55);
    step("R10", 0, 1, 0, 1, 1, 0, 0, 8'hF0, 8'h0F);
    chk("R10", "b_out after reset", b_out, 0);

    // R6: isolation still captures both ports
    step("R6", 0, 0, 1, 0, 0, 0, 0, 8'h5A, 8'hC3);
    chk("R6", "a_oe in isolation", a_oe, 0);
    chk("R6", "b_oe in isolation", b_oe, 0);
    step("R6", 0, 0, 1, 0, 0, 1, 1, 8'h5A, 8'hC3);
    step("R6", 0, 0, 1, 1, 1, 0, 0, 8'h00, 8'h00);
    step("R8", 0, 1, 0, 1, 1, 0, 0, 8'h99, 8'h66);
    chk("R8", "b_out swap", b_out, 8'h5A);
    chk("R8", "a_out swap", a_out, 8'hC3);

    // R4: capture while the stored value is forwarded
    step("R4", 0, 1, 1, 1, 0, 0, 0, 8'h11, 8'h00);
    step("R4", 0, 1, 1, 1, 0, 1, 0, 8'h11, 8'h00);
    step("R4", 0, 1, 1, 1, 0, 1, 0, 8'h22, 8'h00);
    chk("R4", "b_out new store", b_out, 8'h11);
    // R5: strobe held high, then low, data changing
    step("R5", 0, 1, 1, 1, 0, 1, 0, 8'h33, 8'h00);
    chk("R5", "b_out held high strobe", b_out, 8'h11);
    step("R5", 0, 1, 1, 1, 0, 0, 0, 8'h44, 8'h00);
    chk("R5", "b_out held low strobe", b_out, 8'h11);

    // R7: A driven from live B, A register takes the driven value
    step("R2", 0, 0, 0, 0, 0, 0, 0, 8'hEE, 8'h77);
    chk("R2", "a_out live", a_out, 8'h77);
    step("R7", 0, 0, 0, 0, 0, 1, 0, 8'hEE, 8'h77);
    step("R7", 0, 1, 1, 1, 0, 0, 0, 8'hEE, 8'h00);
    chk("R7", "b_out from driven capture", b_out, 8'h77);

    // R9: loop request
    step("R9", 0, 1, 0, 0, 0, 0, 0, 8'h12, 8'h34);
    chk("R9", "contention flag", contention, 1);

    // sweep of every control combination with varied data
    for (int c = 0; c < 64; c++) begin
      for (int k = 0; k < 8; k++) begin
        step("", 0, c[0], c[1], c[2], c[3], c[4] ^ k[0], c[5] ^ k[1],
             W'($urandom), W'($urandom));
      end
    end
    for (int n = 0; n < 1500; n++) begin
      step("", 0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), W'($urandom), W'($urandom));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule